// File: doc/BRIEF.md
# Condition-Code Integer ALU with Shifter

This block is the integer execution stage of a small CISC-style core. Each cycle it takes a destination operand, a source operand, an operation code, a shift-count source and the current extend and zero flags. One clock later it presents the result word and the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C).

It handles six operations. These are plain add, immediate add, add-with-extend, bitwise AND, arithmetic shift left and arithmetic shift right. The extend flag is kept apart from carry. Add-with-extend feeds it back in as a carry-in, and the Z rule for that operation leaves Z set only while every word of a multi-word sum is zero.

Shift counts come either from the low bits of the source operand or from a small immediate field. Decode, operand fetch, the register file and flag storage stay in the surrounding core. The core feeds the stored X and Z flags back into this block.

Top module: `ccr_alu`

## Requirements
- R1: For op code 0 (add) and op code 1 (immediate add), the result is (A + B) mod 2^WIDTH. C is the carry out and X equals C. V is set when A and B share a sign bit that differs from the result's sign bit. N is the result MSB and Z is set when the result is zero.
- R2: Op code 2 (add-with-extend) computes (A + B + x_in) mod 2^WIDTH, with C, X, V and N as in R1. Z is cleared when the result is nonzero and otherwise equals z_in.
- R3: Op code 3 (AND) returns A & B. V and C are cleared, X equals x_in, and N and Z follow the result.
- R4: Op code 4 (shift left) shifts A left by the count and fills low bits with zero. For a nonzero count, C and X both take the last bit shifted out of the top. V is set if the MSB took any value other than its original one at any step of the shift.
- R5: Op code 5 (shift right) shifts A right by the count and copies the original MSB into the vacated high bits. For a nonzero count, C and X both take the last bit shifted out of the bottom. V is always 0.
- R6: With cnt_sel_i = 0, the count is src_b_i[CNT_W-1:0], which is the register value modulo 2^CNT_W. With cnt_sel_i = 1, the count is cnt_imm_i, where the code 0 stands for 2^IMM_W.
- R7: A shift with a count of zero returns A unchanged, clears C, keeps X equal to x_in, and sets N and Z from the result. V is cleared.
- R8: All outputs are registered and appear on the clock edge after the inputs are sampled. While rst_n is low at a rising edge, the result and all flags are cleared.
- R9: Op codes 6 and 7 are reserved. They give a zero result with Z = 1, N = V = C = 0 and X equal to x_in.
- R10: A count of WIDTH or more gives an all-zero result for shift left and a copy of the sign in every bit for shift right. For shift left, C is A[0] when the count equals WIDTH and 0 when it is larger. For shift right, C is the original MSB. For shift left, V is set exactly when A is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code (R9 encoding) |
| src_a_i | input | WIDTH | Destination operand / value to shift |
| src_b_i | input | WIDTH | Source operand / register shift count |
| cnt_sel_i | input | 1 | Count source: 0 register, 1 immediate |
| cnt_imm_i | input | IMM_W | Immediate shift count, 0 means 2^IMM_W |
| x_in_i | input | 1 | Current extend flag |
| z_in_i | input | 1 | Current zero flag |
| result_o | output | WIDTH | Registered result |
| x_o | output | 1 | Extend flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The bench builds the block with WIDTH = 8, CNT_W = 6 and IMM_W = 3. This makes every shift value sweepable against all 64 register counts and all 8 immediate codes. That sweep reaches counts below, equal to and beyond the word width, where the carry and overflow rules change. At this width, every destination value can be paired with a stride of source values for the adds and AND, with both states of the incoming X and Z flags, so carry out, signed overflow and the sticky-zero rule all occur many times.

// File: rtl/ccr_alu_pkg.sv
// Package for the condition-code ALU.
// Holds the operation encoding used by the top module and by its checker.
package ccr_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDI = 3'd1,
        OP_ADDX = 3'd2,
        OP_AND  = 3'd3,
        OP_ASL  = 3'd4,
        OP_ASR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

endpackage

// File: rtl/ccr_alu_adder.sv
// Adder for the condition-code ALU.
// It forms a + b + cin and reports carry out and two's-complement overflow.
// Assumes both operands are WIDTH-bit words and cin is a single bit.
module ccr_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);

    logic [WIDTH:0] wide_sum;

    // Widened sum, so the carry falls out as the top bit.
    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        sum_o    = wide_sum[WIDTH-1:0];
        carry_o  = wide_sum[WIDTH];
        ovf_o    = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    end

endmodule

// File: rtl/ccr_alu_shifter.sv
// Arithmetic shifter for the condition-code ALU.
// Shifts left (zero fill) or right (sign fill) by a count of 0 .. 2^CNT_W-1.
// It reports the last bit shifted out and whether the MSB ever changed (left only).
// Assumes any count, including counts above WIDTH.
module ccr_alu_shifter #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             left_i,
    output logic [WIDTH-1:0] res_o,
    output logic             last_out_o,
    output logic             msb_chg_o
);

    logic [WIDTH-1:0] shl_val;
    logic [WIDTH-1:0] shr_val;
    logic             last_l;
    logic             last_r;
    logic             chg_l;

    // Shifted words. SV shifts already give zero or sign fill for oversize counts.
    always_comb begin
        shl_val = val_i << cnt_i;
        shr_val = WIDTH'($signed(val_i) >>> cnt_i);
        res_o   = left_i ? shl_val : shr_val;
    end

    // Last bit shifted out, for each direction.
    always_comb begin
        int n;
        n      = int'(cnt_i);
        last_l = 1'b0;
        last_r = (n > WIDTH) ? val_i[WIDTH-1] : 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (n != 0 && (WIDTH - n) == i) last_l = val_i[i];
            if (n != 0 && n <= WIDTH && (n - 1) == i) last_r = val_i[i];
        end
        last_out_o = left_i ? last_l : last_r;
    end

    // MSB-change detection for the left shift: the top n+1 bits are not all equal.
    always_comb begin
        int  n;
        logic seen1;
        logic seen0;
        n     = int'(cnt_i);
        seen1 = 1'b0;
        seen0 = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (i >= WIDTH - 1 - n) begin
                if (val_i[i]) seen1 = 1'b1;
                else          seen0 = 1'b1;
            end
        end
        if (n >= WIDTH) chg_l = (val_i != '0);
        else            chg_l = seen1 && seen0;
        msb_chg_o = left_i && chg_l;
    end

endmodule

// File: rtl/ccr_alu.sv
// Condition-code integer ALU, top level.
// It selects the operation and the shift count, derives X/N/Z/V/C, and
// registers the result and flags once.
// Assumes the caller holds the architectural X and Z flags and feeds them back.
module ccr_alu #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6,
    parameter int IMM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    input  logic             cnt_sel_i,
    input  logic [IMM_W-1:0] cnt_imm_i,
    input  logic             x_in_i,
    input  logic             z_in_i,
    output logic [WIDTH-1:0] result_o,
    output logic             x_o,
    output logic             n_o,
    output logic             z_o,
    output logic             v_o,
    output logic             c_o
);
    import ccr_alu_pkg::*;

    localparam int IMM_MAX = 1 << IMM_W;

    alu_op_e          op;
    logic [CNT_W-1:0] shift_cnt;
    logic [WIDTH-1:0] add_sum;
    logic             add_carry;
    logic             add_ovf;
    logic [WIDTH-1:0] sh_res;
    logic             sh_last;
    logic             sh_chg;

    logic [WIDTH-1:0] res_d;
    logic             x_d, n_d, z_d, v_d, c_d;

    // Decode the op code and choose the shift count source.
    always_comb begin
        op = alu_op_e'(op_i);
        if (cnt_sel_i)
            shift_cnt = (cnt_imm_i == '0) ? CNT_W'(IMM_MAX) : CNT_W'(cnt_imm_i);
        else
            shift_cnt = src_b_i[CNT_W-1:0];
    end

    ccr_alu_adder #(.WIDTH(WIDTH)) adder_i (
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .cin_i   ((op == OP_ADDX) ? x_in_i : 1'b0),
        .sum_o   (add_sum),
        .carry_o (add_carry),
        .ovf_o   (add_ovf)
    );

    ccr_alu_shifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) shifter_i (
        .val_i      (src_a_i),
        .cnt_i      (shift_cnt),
        .left_i     (op == OP_ASL),
        .res_o      (sh_res),
        .last_out_o (sh_last),
        .msb_chg_o  (sh_chg)
    );

    // Result mux and the flag rules for each operation.
    always_comb begin
        res_d = '0;
        x_d   = x_in_i;
        v_d   = 1'b0;
        c_d   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDI, OP_ADDX: begin
                res_d = add_sum;
                c_d   = add_carry;
                x_d   = add_carry;
                v_d   = add_ovf;
            end
            OP_AND: begin
                res_d = src_a_i & src_b_i;
            end
            OP_ASL, OP_ASR: begin
                res_d = sh_res;
                c_d   = sh_last;
                x_d   = (shift_cnt == '0) ? x_in_i : sh_last;
                v_d   = sh_chg;
            end
            default: begin
                res_d = '0;
            end
        endcase
        n_d = res_d[WIDTH-1];
        if (op == OP_ADDX) z_d = z_in_i && (res_d == '0);
        else               z_d = (res_d == '0);
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            x_o      <= 1'b0;
            n_o      <= 1'b0;
            z_o      <= 1'b0;
            v_o      <= 1'b0;
            c_o      <= 1'b0;
        end else begin
            result_o <= res_d;
            x_o      <= x_d;
            n_o      <= n_d;
            z_o      <= z_d;
            v_o      <= v_d;
            c_o      <= c_d;
        end
    end

endmodule

// File: rtl/ccr_alu_checker.sv
// Checker for the condition-code ALU, bound into every ccr_alu instance.
// It relates the registered outputs to the inputs of the previous edge.
module ccr_alu_checker #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [CNT_W-1:0] cnt_reg_i,
    input logic             cnt_sel_i,
    input logic             x_in_i,
    input logic             z_in_i,
    input logic [WIDTH-1:0] result_o,
    input logic             x_o,
    input logic             n_o,
    input logic             z_o,
    input logic             v_o,
    input logic             c_o
);
    import ccr_alu_pkg::*;

    logic past_ok;
    logic edge_seen = 1'b0;

    // Marks the edges whose previous edge had reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Marks that at least one edge has gone by.
    always_ff @(posedge clk) edge_seen <= 1'b1;

    p_reset_clears_r8: assert property (@(posedge clk)
        edge_seen && !$past(rst_n) |-> (result_o == '0) && !x_o && !n_o && !z_o && !v_o && !c_o);

    p_and_clears_vc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_AND |-> !v_o && !c_o);

    p_and_keeps_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_AND |-> x_o == $past(x_in_i));

    p_addx_z_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_ADDX && !$past(z_in_i) |-> !z_o);

    p_asr_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_ASR |-> !v_o);

    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_i) == OP_ASL || $past(op_i) == OP_ASR)
        && !$past(cnt_sel_i) && $past(cnt_reg_i) == '0
        |-> !c_o && !v_o && x_o == $past(x_in_i));

    p_imm_shift_xc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_i) == OP_ASL || $past(op_i) == OP_ASR) && $past(cnt_sel_i)
        |-> x_o == c_o);

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) >= 3'd6
        |-> result_o == '0 && z_o && !n_o && !v_o && !c_o && x_o == $past(x_in_i));

    p_nz_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) != OP_ADDX |-> z_o == (result_o == '0) && n_o == result_o[WIDTH-1]);

endmodule

bind ccr_alu ccr_alu_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .cnt_reg_i (src_b_i[CNT_W-1:0]),
    .cnt_sel_i (cnt_sel_i),
    .x_in_i    (x_in_i),
    .z_in_i    (z_in_i),
    .result_o  (result_o),
    .x_o       (x_o),
    .n_o       (n_o),
    .z_o       (z_o),
    .v_o       (v_o),
    .c_o       (c_o)
);

// File: tb/ccr_alu_tb_top.sv
// Bench for ccr_alu at WIDTH=8. It sweeps operands and counts, and compares
// against a step-by-step arithmetic model.
module ccr_alu_tb_top;

    localparam int W  = 8;
    localparam int CW = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = '0;
    logic [W-1:0]  a = '0, b = '0;
    logic          sel = 1'b0;
    logic [IW-1:0] imm = '0;
    logic          xin = 1'b0, zin = 1'b0;
    logic [W-1:0]  res;
    logic          xo, no, zo, vo, co;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    ccr_alu #(.WIDTH(W), .CNT_W(CW), .IMM_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_a_i(a), .src_b_i(b),
        .cnt_sel_i(sel), .cnt_imm_i(imm), .x_in_i(xin), .z_in_i(zin),
        .result_o(res), .x_o(xo), .n_o(no), .z_o(zo), .v_o(vo), .c_o(co)
    );

    // Reference model: returns {result, X, N, Z, V, C}.
    function automatic logic [W+4:0] model(input int o, input logic [W-1:0] da,
                                           input logic [W-1:0] sb, input bit s,
                                           input int im, input bit xi, input bit zi);
        int r, cnt, out, msb0;
        bit x, n, z, v, c;
        x = xi; v = 0; c = 0; r = 0;
        cnt = s ? ((im == 0) ? 8 : im) : (int'(sb) % 64);
        case (o)
            0, 1, 2: begin
                r = int'(da) + int'(sb) + ((o == 2) ? int'(xi) : 0);
                c = (r >= 256); x = c; r = r % 256;
                v = (da[W-1] == sb[W-1]) && (((r >> 7) & 1) != int'(da[W-1]));
            end
            3: r = int'(da & sb);
            4, 5: begin
                r = int'(da); msb0 = (r >> 7) & 1; out = 0;
                for (int k = 0; k < cnt; k++) begin
                    if (o == 4) begin
                        out = (r >> 7) & 1; r = (r << 1) % 256;
                        if (((r >> 7) & 1) != msb0) v = 1;
                    end else begin
                        out = r & 1; r = (r >> 1) | (r & 128);
                    end
                end
                c = (out != 0);
                if (cnt != 0) x = c;
            end
            default: r = 0;
        endcase
        n = ((r >> 7) & 1) != 0;
        z = (o == 2) ? (zi && r == 0) : (r == 0);
        return {W'(r), x, n, z, v, c};
    endfunction

    // Apply one vector and check the output one edge later.
    task automatic run(input int o, input int va, input int vb, input bit s,
                       input int im, input bit xi, input bit zi, input string tag);
        logic [W+4:0] exp, got;
        op = 3'(o); a = W'(va); b = W'(vb); sel = s; imm = IW'(im); xin = xi; zin = zi;
        exp = model(o, W'(va), W'(vb), s, im, xi, zi);
        @(posedge clk); @(negedge clk);
        got = {res, xo, no, zo, vo, co};
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h sel=%0b imm=%0d x=%0b z=%0b: actual {res,X,N,Z,V,C}=%h_%b expected %h_%b",
                     tag, o, va, vb, s, im, xi, zi, got[W+4:5], got[4:0], exp[W+4:5], exp[4:0]);
        end
    endtask

    initial begin
        // R8: outputs cleared while reset is held
        op = 3'd1; a = 8'hff; b = 8'h01; xin = 1; zin = 1;
        @(negedge clk); @(negedge clk);
        vectors++;
        if ({res, xo, no, zo, vo, co} !== '0) begin
            fails++;
            $display("FAIL R8 reset: actual %h_%b expected 00_00000", res, {xo, no, zo, vo, co});
        end
        rst_n = 1'b1;

        for (int va = 0; va < 256; va++)
            for (int j = 0; j < 16; j++) begin
                run(0, va, j * 17, 0, 0, 0, 0, "R1 add");
                run(1, va, 255 - j * 17, 0, 0, 1, 1, "R1 addi");
                run(3, va, j * 17 ^ 8'h5a, 0, 0, bit'(j & 1), bit'(va & 1), "R3 and");
                for (int xz = 0; xz < 4; xz++)
                    run(2, va, j * 17, 0, 0, bit'(xz & 1), bit'(xz >> 1), "R2 addx");
            end

        for (int va = 0; va < 256; va++) begin
            for (int cn = 0; cn < 64; cn++) begin
                run(4, va, cn | 8'hc0, 0, 0, bit'(va & 1), 0,
                    (cn == 0) ? "R7 asl zero" : (cn >= W) ? "R10 asl wide" : "R4 asl");
                run(5, va, cn, 0, 0, bit'(~va & 1), 0,
                    (cn == 0) ? "R7 asr zero" : (cn >= W) ? "R10 asr wide" : "R5 asr");
            end
            for (int im = 0; im < 8; im++) begin
                run(4, va, 8'h00, 1, im, 1, 0, "R6 asl imm");
                run(5, va, 8'h00, 1, im, 0, 1, "R6 asr imm");
            end
        end

        for (int va = 0; va < 256; va += 51)
            for (int o = 6; o < 8; o++)
                for (int xi = 0; xi < 2; xi++)
                    run(o, va, 255 - va, 0, 0, bit'(xi), 0, "R9 reserved");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule